// File: doc/BRIEF.md
# Transceiver wake and fault flag manager

This block holds three sticky status flags for the control core of a bus transceiver. The first is a wake flag, raised by a local or remote wake-up. The second is a wake-source flag, which marks that the wake came from the local wake pin. The third is a bus-failure flag, raised when the driver keeps meeting a bus short while it transmits. Each flag is set and cleared by power-on, by entry into or exit from Normal mode, and by its own events. The flags drive the core's status-output multiplexer.

The local wake pin is asynchronous. It passes through a two-flop synchroniser and then a persistence filter. Both a rising and a falling accepted transition count as a local wake. The bus-failure flag needs a run of consecutive transmit cycles that saw a short, counted only in Normal mode. Any clean cycle restarts the run.

Top module: `xcvr_flag_mgr`

## Requirements
- R1: After power-on reset (`por_n` low), the wake flag and the wake-source flag read 1 and the bus-failure flag reads 0. The mode encoding is Normal=3'b000, Listen-only=3'b001, Standby=3'b010, Go-to-Sleep=3'b011, Sleep=3'b100, and any other code counts as not Normal.
- R2: A rising or a falling transition on `wake_pin_i` sets both the wake flag and the wake-source flag. The new level must persist for at least WAKE_FILT consecutive clock samples after synchronisation.
- R3: A pin excursion shorter than WAKE_FILT clock samples, together with its return, sets neither flag.
- R4: A one-cycle pulse on `rwake_i` sets the wake flag and leaves the wake-source flag unchanged.
- R5: When the mode changes from a non-Normal code to Normal, the wake flag is cleared on the next clock edge. The clear wins over a wake event in the same cycle.
- R6: A rising edge of `uv_i` clears the wake flag and wins over a wake event in the same cycle. While `uv_i` stays high, later wake events set the flag again.
- R7: Leaving Normal mode clears the wake-source flag. `wsrc_rd_o` equals the wake-source flag while the mode is Normal and is 0 in every other mode.
- R8: In Normal mode, the bus-failure flag sets at the end of the FAIL_CYCLES-th consecutive shorted transmit cycle. A transmit cycle is `txd_i` low (dominant) for one or more cycles followed by high (recessive). It counts as shorted if `bus_short_i` was high in at least one of its dominant cycles.
- R9: A transmit cycle that completes without a short restarts the count from zero. `bus_short_i` while `txd_i` is high has no effect.
- R10: Entering Normal mode clears the bus-failure flag. Outside Normal mode, transmit cycles are not counted and any partial count is dropped. Leaving Normal mode keeps the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mode_i | input | 3 | Operating mode code |
| uv_i | input | 1 | Supply undervoltage indication |
| rwake_i | input | 1 | Remote wake-up event pulse from the bus pattern detector |
| wake_pin_i | input | 1 | Asynchronous local wake pin level |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| bus_short_i | input | 1 | Per-cycle bus short indication from the driver monitor |
| wake_flag_o | output | 1 | Wake flag |
| wsrc_flag_o | output | 1 | Wake-source (local) flag |
| wsrc_rd_o | output | 1 | Wake-source flag gated for reading in Normal mode |
| busfail_flag_o | output | 1 | Bus-failure flag |

## Verification
The assertions assume that `mode_i`, `uv_i`, `rwake_i`, `txd_i` and `bus_short_i` are synchronous to `clk`. Only `wake_pin_i` may change at any time. The bus-failure checks also assume that `bus_short_i` matters only while `txd_i` is dominant.

The stimulus drives every synchronous input on the falling edge. It holds the wake pin steady from reset until the filter has locked onto its level. It also pulses `bus_short_i` during recessive gaps on purpose, to show that those pulses are ignored rather than to break the timing assumption.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

  localparam logic [2:0] MODE_NORMAL  = 3'd0;
  localparam logic [2:0] MODE_LISTEN  = 3'd1;
  localparam logic [2:0] MODE_STANDBY = 3'd2;
  localparam logic [2:0] MODE_GOSLEEP = 3'd3;
  localparam logic [2:0] MODE_SLEEP   = 3'd4;

  function automatic logic is_normal(input logic [2:0] m);
    return m == MODE_NORMAL;
  endfunction

  // run counter has reached the last sample of the persistence window
  function automatic logic filt_done(input int unsigned run, input int unsigned limit);
    return run + 1 >= limit;
  endfunction

  // next consecutive shorted-cycle count, saturating at limit
  function automatic int unsigned fail_next(input int unsigned cnt, input logic shorted,
                                            input int unsigned limit);
    if (!shorted) return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction

endpackage

// File: rtl/xfm_wake_filter.sv
module xfm_wake_filter #(
  parameter int unsigned WAKE_FILT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic edge_o
);
  import xfm_pkg::*;

  localparam int unsigned RW = (WAKE_FILT < 2) ? 1 : $clog2(WAKE_FILT + 1);

  logic          s1_q, s2_q;
  logic          lvl_q, vld_q, edge_q;
  logic [RW-1:0] run_q;
  logic          hit, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign hit    = filt_done(32'(run_q), WAKE_FILT);
  assign accept = vld_q && (s2_q != lvl_q) && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      vld_q  <= 1'b0;
      run_q  <= '0;
      edge_q <= 1'b0;
    end else begin
      edge_q <= accept;
      if (!vld_q) begin
        // lock onto the initial level without reporting an edge
        if (s2_q != lvl_q) begin
          lvl_q <= s2_q;
          run_q <= '0;
        end else if (hit) begin
          vld_q <= 1'b1;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else if (s2_q == lvl_q) begin
        run_q <= '0;
      end else if (hit) begin
        lvl_q <= s2_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign edge_o = edge_q;

  AST_EDGE_FLIPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q |-> (lvl_q != $past(lvl_q)));  // R2
  AST_EDGE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q |-> $past(vld_q));  // R3
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_q) < WAKE_FILT);  // R3

endmodule

// File: rtl/xfm_wake_flags.sv
module xfm_wake_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_local_i,
  input  logic set_remote_i,
  input  logic clr_wake_i,
  input  logic clr_src_i,
  output logic wake_o,
  output logic src_o
);

  logic wake_q, src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b1;
      src_q  <= 1'b1;
    end else begin
      if (clr_wake_i)                       wake_q <= 1'b0;
      else if (set_local_i || set_remote_i) wake_q <= 1'b1;

      if (clr_src_i)                        src_q <= 1'b0;
      else if (set_local_i && !clr_wake_i)  src_q <= 1'b1;
    end
  end

  assign wake_o = wake_q;
  assign src_o  = src_q;

  AST_WAKE_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wake_i |=> !wake_q);  // R5
  AST_REMOTE_SETS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_remote_i && !clr_wake_i) |=> wake_q);  // R4
  AST_SRC_FROM_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_q) |-> $past(set_local_i));  // R2
  AST_SRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_src_i |=> !src_q);  // R7

endmodule

// File: rtl/xfm_busfail.sv
module xfm_busfail #(
  parameter int unsigned FAIL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic clr_i,
  input  logic txd_i,
  input  logic short_i,
  output logic flag_o
);
  import xfm_pkg::*;

  localparam int unsigned CW = $clog2(FAIL_CYCLES + 1);

  logic          txd_q, seen_q, flag_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cyc_done;

  assign cyc_done = active_i && txd_i && !txd_q;
  assign cnt_nx   = CW'(fail_next(32'(cnt_q), seen_q, FAIL_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q  <= 1'b1;
      seen_q <= 1'b0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      txd_q <= txd_i;
      if (!active_i || cyc_done)     seen_q <= 1'b0;
      else if (!txd_i && short_i)    seen_q <= 1'b1;

      if (!active_i)                 cnt_q <= '0;
      else if (cyc_done)             cnt_q <= cnt_nx;

      if (clr_i)                     flag_q <= 1'b0;
      else if (cyc_done && 32'(cnt_nx) == FAIL_CYCLES) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= FAIL_CYCLES);  // R8
  AST_FAIL_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(cyc_done && seen_q) && 32'($past(cnt_q)) + 1 >= FAIL_CYCLES));  // R8
  AST_CLEAN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !seen_q) |=> (cnt_q == '0));  // R9
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (cnt_q == '0));  // R10

endmodule

// File: rtl/xcvr_flag_mgr.sv
module xcvr_flag_mgr #(
  parameter int unsigned WAKE_FILT   = 4,
  parameter int unsigned FAIL_CYCLES = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [2:0] mode_i,
  input  logic       uv_i,
  input  logic       rwake_i,
  input  logic       wake_pin_i,
  input  logic       txd_i,
  input  logic       bus_short_i,
  output logic       wake_flag_o,
  output logic       wsrc_flag_o,
  output logic       wsrc_rd_o,
  output logic       busfail_flag_o
);
  import xfm_pkg::*;

  logic [2:0] mode_q;
  logic       uv_q;
  logic       in_normal, normal_entry, normal_exit, uv_rise, local_evt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= MODE_STANDBY;
      uv_q   <= 1'b0;
    end else begin
      mode_q <= mode_i;
      uv_q   <= uv_i;
    end
  end

  assign in_normal    = is_normal(mode_i);
  assign normal_entry = in_normal && !is_normal(mode_q);
  assign normal_exit  = !in_normal && is_normal(mode_q);
  assign uv_rise      = uv_i && !uv_q;

  xfm_wake_filter #(.WAKE_FILT(WAKE_FILT)) u_filt (
    .clk    (clk),
    .rst_n  (por_n),
    .pin_i  (wake_pin_i),
    .edge_o (local_evt)
  );

  xfm_wake_flags u_wflags (
    .clk          (clk),
    .rst_n        (por_n),
    .set_local_i  (local_evt),
    .set_remote_i (rwake_i),
    .clr_wake_i   (normal_entry || uv_rise),
    .clr_src_i    (normal_exit),
    .wake_o       (wake_flag_o),
    .src_o        (wsrc_flag_o)
  );

  xfm_busfail #(.FAIL_CYCLES(FAIL_CYCLES)) u_bfail (
    .clk      (clk),
    .rst_n    (por_n),
    .active_i (in_normal),
    .clr_i    (normal_entry),
    .txd_i    (txd_i),
    .short_i  (bus_short_i),
    .flag_o   (busfail_flag_o)
  );

  assign wsrc_rd_o = wsrc_flag_o && in_normal;

  AST_UV_CLEARS_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    uv_rise |=> !wake_flag_o);  // R6
  AST_ENTRY_CLEARS_FAIL: assert property (@(posedge clk) disable iff (!por_n)
    normal_entry |=> !busfail_flag_o);  // R10
  AST_ENTRY_CLEARS_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    normal_entry |=> !wake_flag_o);  // R5
  AST_FAIL_HOLDS_OUTSIDE: assert property (@(posedge clk) disable iff (!por_n)
    (busfail_flag_o && !in_normal) |=> busfail_flag_o);  // R10

endmodule

// File: tb/xcvr_flag_mgr_bench.sv
module xcvr_flag_mgr_bench;
  import xfm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int FILT       = 3;
  localparam int FAILN      = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [2:0] mode = MODE_STANDBY;
  logic       uv = 1'b0, rwake = 1'b0, wpin = 1'b0, txd = 1'b1, bshort = 1'b0;
  logic       wake_f, wsrc_f, wsrc_rd, bfail_f;
  int         checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_flag_mgr #(.WAKE_FILT(FILT), .FAIL_CYCLES(FAILN)) u_xcvr_flag_mgr (
    .clk(clk), .por_n(por_n), .mode_i(mode), .uv_i(uv), .rwake_i(rwake),
    .wake_pin_i(wpin), .txd_i(txd), .bus_short_i(bshort),
    .wake_flag_o(wake_f), .wsrc_flag_o(wsrc_f), .wsrc_rd_o(wsrc_rd),
    .busfail_flag_o(bfail_f)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic go(input logic [2:0] m);
    mode = m;
    tick(2);
  endtask

  task automatic pin_glitch(input int w);
    wpin = ~wpin;
    tick(w);
    wpin = ~wpin;
    tick(FILT + 8);
  endtask

  task automatic tx_cycle(input int dom_len, input logic flt, input logic flt_rec);
    txd = 1'b0;
    for (int i = 0; i < dom_len; i++) begin
      bshort = flt && (i == dom_len - 1);
      tick(1);
    end
    bshort = flt_rec;
    txd = 1'b1;
    tick(2);
    bshort = 1'b0;
  endtask

  task automatic fresh_normal();
    go(MODE_STANDBY);
    go(MODE_NORMAL);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    por_n = 1'b1;
    tick(12);
    // R1 reset state
    chk(wake_f, 1'b1, "R1 wake flag after reset");
    chk(wsrc_f, 1'b1, "R1 source flag after reset");
    chk(bfail_f, 1'b0, "R1 bus-failure flag after reset");
    chk(wsrc_rd, 1'b0, "R7 source read gated outside Normal");

    go(MODE_NORMAL);
    chk(wake_f, 1'b0, "R5 entry clears wake");
    chk(wsrc_rd, 1'b1, "R7 source readable in Normal");
    go(MODE_STANDBY);
    chk(wsrc_f, 1'b0, "R7 exit clears source");

    // R2 / R3 sweep over pin excursion width
    for (int w = 1; w <= FILT + 3; w++) begin
      logic exp;
      exp = (w >= FILT);
      pin_glitch(w);
      chk(wake_f, exp, $sformatf("R2 R3 wake after pin width %0d", w));
      go(MODE_NORMAL);
      chk(wsrc_rd, exp, $sformatf("R2 R3 source after pin width %0d", w));
      chk(wake_f, 1'b0, "R5 entry clears wake after sweep");
      go(MODE_STANDBY);
      chk(wsrc_f, 1'b0, "R7 exit clears source after sweep");
    end

    // R4 remote wake
    rwake = 1'b1; tick(1); rwake = 1'b0; tick(1);
    chk(wake_f, 1'b1, "R4 remote sets wake");
    chk(wsrc_f, 1'b0, "R4 remote leaves source");
    // R5 clear wins over same-cycle remote
    mode = MODE_NORMAL; rwake = 1'b1; tick(1); rwake = 1'b0; tick(1);
    chk(wake_f, 1'b0, "R5 entry wins over remote");
    go(MODE_STANDBY);

    // R6 undervoltage
    rwake = 1'b1; tick(1); rwake = 1'b0; tick(1);
    uv = 1'b1; tick(2);
    chk(wake_f, 1'b0, "R6 uv rise clears wake");
    rwake = 1'b1; tick(1); rwake = 1'b0; tick(1);
    chk(wake_f, 1'b1, "R6 wake sets while uv held");
    uv = 1'b0; tick(2);
    uv = 1'b1; rwake = 1'b1; tick(1); rwake = 1'b0; tick(1);
    chk(wake_f, 1'b0, "R6 uv rise wins over remote");
    uv = 1'b0; tick(2);

    // R8 sweep over run length
    for (int k = 1; k <= FAILN + 2; k++) begin
      fresh_normal();
      tx_cycle(2, 1'b0, 1'b0);
      for (int j = 0; j < k; j++) tx_cycle(1 + (j % 3), 1'b1, 1'b0);
      chk(bfail_f, (k >= FAILN), $sformatf("R8 flag after %0d shorted cycles", k));
    end
    go(MODE_LISTEN);
    chk(bfail_f, 1'b1, "R10 flag kept after leaving Normal");
    go(MODE_NORMAL);
    chk(bfail_f, 1'b0, "R10 entry clears flag");

    // R9 clean cycle restarts count
    fresh_normal();
    for (int j = 0; j < FAILN - 1; j++) tx_cycle(2, 1'b1, 1'b0);
    tx_cycle(2, 1'b0, 1'b0);
    for (int j = 0; j < FAILN - 1; j++) tx_cycle(2, 1'b1, 1'b0);
    chk(bfail_f, 1'b0, "R9 clean cycle restarts count");
    tx_cycle(1, 1'b1, 1'b0);
    chk(bfail_f, 1'b1, "R9 run completes after restart");

    // R9 short while recessive ignored
    fresh_normal();
    for (int j = 0; j < FAILN + 2; j++) tx_cycle(2, 1'b0, 1'b1);
    chk(bfail_f, 1'b0, "R9 recessive short ignored");

    // R10 no counting outside Normal, partial count dropped
    go(MODE_LISTEN);
    for (int j = 0; j < FAILN + 1; j++) tx_cycle(2, 1'b1, 1'b0);
    chk(bfail_f, 1'b0, "R10 no count in Listen-only");
    go(MODE_NORMAL);
    for (int j = 0; j < FAILN - 1; j++) tx_cycle(2, 1'b1, 1'b0);
    go(MODE_STANDBY);
    go(MODE_NORMAL);
    tx_cycle(2, 1'b1, 1'b0);
    chk(bfail_f, 1'b0, "R10 partial count dropped on exit");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule